// File: doc/BRIEF.md
# Operand Effective Address Generator

This block resolves the memory operand address for one instruction of a small 8-bit processor with a 16-bit address space. The controller presents an addressing-mode code, the program counter (already pointing past the opcode) and the two index registers, then pulses `start`. The block fetches the operand bytes through a byte-wide synchronous read port, chases any pointer that the mode needs, applies the index, and returns the 16-bit effective address. It also returns the advanced program counter and a flag that reports whether indexing moved the address into another 256-byte page. The controller uses that flag to charge the extra cycle.

The read port has one cycle of latency: a byte requested while `rd_en` is high must be on `rd_data` in the following cycle. At most one byte is requested per cycle. A single adder serves every mode. It wraps inside page zero, carries across the full 16 bits, or adds a sign-extended offset, depending on the mode.

Top module: `eff_addr_unit`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `page_cross` and `rd_en` are 0 and `ea` is 0x0000.
- R2: Operand bytes are read from consecutive program counter addresses, the low byte first. `pc_next` equals `pc_in` plus the operand length, which is 1 for codes 0, 1, 2, 7, 8 and 9 and is 2 for codes 3, 4, 5 and 6. The sum wraps modulo 65536.
- R3: Zero page (code 0), zero page plus X (code 1) and zero page plus Y (code 2) give `{0x00, (op + index) mod 256}` and never raise `page_cross`. Codes 10 to 15 behave as code 0.
- R4: Absolute (code 3), absolute plus X (code 4) and absolute plus Y (code 5) give `{hi,lo} + index` modulo 65536. `page_cross` is 1 exactly when the high byte of the sum differs from `hi`.
- R5: Indexed indirect (code 7) forms `z = (op + X) mod 256`, then reads the target low byte from `z` and the high byte from `(z + 1) mod 256`. `page_cross` is 0.
- R6: Indirect indexed (code 8) reads a pointer, with its low byte at `op` and its high byte at `(op + 1) mod 256`. The result is pointer + Y modulo 65536, and `page_cross` is 1 when the high byte changes.
- R7: Indirect (code 6) forms `p = {hi,lo}` from the operand. The result takes its low byte from address `p` and its high byte from `p + 1`, with a full 16-bit increment.
- R8: Relative (code 9) gives `pc_in + 1 + sign_extend(op)`, and `page_cross` is 0.
- R9: `page_cross` is cleared in the cycle after a start is accepted. `ea` and `page_cross` hold their values until the next result.
- R10: `busy` is high from the cycle after an accepted start until the result cycle. `done` is a single-cycle pulse with the result. The number of read cycles is 1 for codes 0, 1, 2 and 9, 2 for codes 3, 4 and 5, 3 for codes 7 and 8, and 4 for code 6.
- R11: A `start` seen while `busy` is high is ignored, and the running request completes with its own inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new address computation (taken when not busy) |
| mode | input | 4 | Addressing-mode code |
| pc_in | input | 16 | Address of the first operand byte |
| x_in | input | 8 | X index value |
| y_in | input | 8 | Y index value |
| rd_en | output | 1 | Read request this cycle |
| rd_addr | output | 16 | Read address |
| rd_data | input | 8 | Read data, valid one cycle after the request |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse: result valid |
| ea | output | 16 | Effective address |
| page_cross | output | 1 | Indexing moved the address to another page |
| pc_next | output | 16 | Program counter after the operand bytes |

## Verification
Two events can share one cycle: the result of one request is presented, and the next request is accepted. A new start that arrives in the cycle where `done` pulses must clear a `page_cross` that the previous result has just set. The bench provokes this by raising `start` for a zero-page request in the same cycle that an absolute-plus-X request with X = 0xFF reports its crossing. It then requires `page_cross` low and `busy` high one cycle later, followed by the correct zero-page result. The bench also raises `start` with different inputs in the middle of a run and checks that the running result is unchanged.

// File: rtl/eag_pkg.sv
package eag_pkg;

  typedef enum logic [3:0] {
    AM_ZP   = 4'd0,
    AM_ZPX  = 4'd1,
    AM_ZPY  = 4'd2,
    AM_ABS  = 4'd3,
    AM_ABSX = 4'd4,
    AM_ABSY = 4'd5,
    AM_IND  = 4'd6,
    AM_IDX  = 4'd7,
    AM_IDY  = 4'd8,
    AM_REL  = 4'd9
  } am_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_F_LO,
    ST_F_HI,
    ST_G_OP1,
    ST_G_OP2,
    ST_P_LO,
    ST_P_HI,
    ST_G_PTR
  } st_e;

  localparam logic [3:0] AM_LAST = 4'd9;

  function automatic am_e decode_mode(input logic [3:0] code);
    return (code > AM_LAST) ? AM_ZP : am_e'(code);
  endfunction

  function automatic logic two_byte_operand(input am_e m);
    return (m == AM_ABS) || (m == AM_ABSX) || (m == AM_ABSY) || (m == AM_IND);
  endfunction

  function automatic logic zp_pointer_mode(input am_e m);
    return (m == AM_IDX) || (m == AM_IDY);
  endfunction

endpackage

// File: rtl/eag_index_add.sv
module eag_index_add #(
  parameter int DW = 8
) (
  input  logic [2*DW-1:0] base,
  input  logic [DW-1:0]   idx,
  input  logic            wrap_page,
  input  logic            signed_idx,
  output logic [2*DW-1:0] sum,
  output logic            crossed
);
  localparam int AW = 2 * DW;

  logic [AW-1:0] ext;
  logic [AW-1:0] full;

  always_comb begin
    ext  = signed_idx ? {{DW{idx[DW-1]}}, idx} : {{DW{1'b0}}, idx};
    full = base + ext;
    if (wrap_page) begin
      sum     = {base[AW-1:DW], full[DW-1:0]};
      crossed = 1'b0;
    end else begin
      sum     = full;
      crossed = (full[AW-1:DW] != base[AW-1:DW]);
    end
  end
endmodule

// File: rtl/eag_ptr_step.sv
module eag_ptr_step #(
  parameter int DW = 8
) (
  input  logic [2*DW-1:0] ptr,
  input  logic            in_zero_page,
  output logic [2*DW-1:0] ptr_nxt
);
  localparam int AW = 2 * DW;

  logic [DW-1:0] lo_inc;
  logic [AW-1:0] full_inc;

  always_comb begin
    lo_inc   = ptr[DW-1:0] + {{(DW-1){1'b0}}, 1'b1};
    full_inc = ptr + {{(AW-1){1'b0}}, 1'b1};
    ptr_nxt  = in_zero_page ? {{DW{1'b0}}, lo_inc} : full_inc;
  end
endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [3:0]      mode,
  input  logic [2*DW-1:0] pc_in,
  input  logic [DW-1:0]   x_in,
  input  logic [DW-1:0]   y_in,
  output logic            rd_en,
  output logic [2*DW-1:0] rd_addr,
  input  logic [DW-1:0]   rd_data,
  output logic            busy,
  output logic            done,
  output logic [2*DW-1:0] ea,
  output logic            page_cross,
  output logic [2*DW-1:0] pc_next
);
  import eag_pkg::*;

  localparam int AW = 2 * DW;
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  st_e           st;
  am_e           mode_q;
  logic [DW-1:0] x_q, y_q, lo_q;
  logic [AW-1:0] pcr, ptr_q, ea_q;
  logic          ptr_zp, cross_q, done_q;

  logic [AW-1:0] add_base, add_sum, ptr_nxt;
  logic [DW-1:0] add_idx;
  logic          add_wrap, add_signed, add_cross;

  eag_index_add #(.DW(DW)) u_add (
    .base      (add_base),
    .idx       (add_idx),
    .wrap_page (add_wrap),
    .signed_idx(add_signed),
    .sum       (add_sum),
    .crossed   (add_cross)
  );

  eag_ptr_step #(.DW(DW)) u_step (
    .ptr         (ptr_q),
    .in_zero_page(ptr_zp),
    .ptr_nxt     (ptr_nxt)
  );

  // one shared adder, inputs chosen by phase
  always_comb begin
    add_base   = '0;
    add_idx    = '0;
    add_wrap   = 1'b0;
    add_signed = 1'b0;
    case (st)
      ST_G_OP1: begin
        if (mode_q == AM_REL) begin
          add_base   = pcr;
          add_idx    = rd_data;
          add_signed = 1'b1;
        end else begin
          add_base = {{DW{1'b0}}, rd_data};
          add_wrap = 1'b1;
          if (mode_q == AM_ZPX || mode_q == AM_IDX) add_idx = x_q;
          else if (mode_q == AM_ZPY)                add_idx = y_q;
        end
      end
      ST_G_OP2: begin
        add_base = {rd_data, lo_q};
        if (mode_q == AM_ABSX)      add_idx = x_q;
        else if (mode_q == AM_ABSY) add_idx = y_q;
      end
      ST_G_PTR: begin
        add_base = {rd_data, lo_q};
        if (mode_q == AM_IDY) add_idx = y_q;
      end
      default: ;
    endcase
  end

  // read port: one request per cycle, data returns next cycle
  always_comb begin
    rd_en   = 1'b0;
    rd_addr = '0;
    case (st)
      ST_F_LO, ST_F_HI: begin rd_en = 1'b1; rd_addr = pcr;     end
      ST_P_LO:          begin rd_en = 1'b1; rd_addr = ptr_q;   end
      ST_P_HI:          begin rd_en = 1'b1; rd_addr = ptr_nxt; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      mode_q  <= AM_ZP;
      x_q     <= '0;
      y_q     <= '0;
      lo_q    <= '0;
      pcr     <= '0;
      ptr_q   <= '0;
      ptr_zp  <= 1'b0;
      ea_q    <= '0;
      cross_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            mode_q  <= decode_mode(mode);
            x_q     <= x_in;
            y_q     <= y_in;
            pcr     <= pc_in;
            cross_q <= 1'b0;
            st      <= ST_F_LO;
          end
        end
        ST_F_LO: begin
          pcr <= pcr + ONE;
          st  <= two_byte_operand(mode_q) ? ST_F_HI : ST_G_OP1;
        end
        ST_F_HI: begin
          lo_q <= rd_data;
          pcr  <= pcr + ONE;
          st   <= ST_G_OP2;
        end
        ST_G_OP1: begin
          if (zp_pointer_mode(mode_q)) begin
            ptr_q  <= {{DW{1'b0}}, add_sum[DW-1:0]};
            ptr_zp <= 1'b1;
            st     <= ST_P_LO;
          end else begin
            ea_q    <= add_sum;
            cross_q <= add_cross && (mode_q != AM_REL);
            done_q  <= 1'b1;
            st      <= ST_IDLE;
          end
        end
        ST_G_OP2: begin
          if (mode_q == AM_IND) begin
            ptr_q  <= {rd_data, lo_q};
            ptr_zp <= 1'b0;
            st     <= ST_P_LO;
          end else begin
            ea_q    <= add_sum;
            cross_q <= add_cross;
            done_q  <= 1'b1;
            st      <= ST_IDLE;
          end
        end
        ST_P_LO: st <= ST_P_HI;
        ST_P_HI: begin
          lo_q <= rd_data;
          st   <= ST_G_PTR;
        end
        ST_G_PTR: begin
          ea_q    <= add_sum;
          cross_q <= add_cross;
          done_q  <= 1'b1;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (st != ST_IDLE);
  assign done       = done_q;
  assign ea         = ea_q;
  assign page_cross = cross_q;
  assign pc_next    = pcr;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> busy); // R10
  AST_ZP_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
    (done && (mode_q == AM_ZP || mode_q == AM_ZPX || mode_q == AM_ZPY))
      |-> (ea[AW-1:DW] == '0 && !page_cross)); // R3
  AST_CROSS_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> !page_cross); // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(ea) && $stable(page_cross))); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(mode_q) && $stable(x_q) && $stable(y_q))); // R11
  AST_REL_NO_CROSS: assert property (@(posedge clk) disable iff (rst)
    (done && mode_q == AM_REL) |-> !page_cross); // R8

endmodule

// File: tb/eff_addr_unit_bench.sv
module eff_addr_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] pc_in = '0;
  logic [7:0]  x_in = '0, y_in = '0;
  logic        rd_en;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data = '0;
  logic        busy, done, page_cross;
  logic [15:0] ea, pc_next;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  eff_addr_unit u_eff_addr_unit (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .pc_in(pc_in),
    .x_in(x_in), .y_in(y_in), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .done(done), .ea(ea),
    .page_cross(page_cross), .pc_next(pc_next)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    logic [7:0] t1, t2;
    t1 = 8'(a[7:0] * 8'd37);
    t2 = 8'(a[15:8] * 8'd11);
    return t1 ^ t2 ^ 8'h5C;
  endfunction

  always_ff @(posedge clk) if (rd_en) rd_data <= mem_byte(rd_addr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic expect_of(input logic [3:0] m, input logic [15:0] p,
                           input logic [7:0] xv, input logic [7:0] yv,
                           output logic [15:0] e, output logic c,
                           output logic [15:0] pn, output int nr);
    logic [7:0] b0, b1, z, zn;
    logic [15:0] q, t;
    b0 = mem_byte(p);
    b1 = mem_byte(16'(p + 16'd1));
    c = 1'b0; pn = 16'(p + 16'd1); nr = 1; e = {8'h00, b0};
    case (m)
      4'd1: e = {8'h00, 8'(b0 + xv)};
      4'd2: e = {8'h00, 8'(b0 + yv)};
      4'd3: begin e = {b1, b0}; pn = 16'(p + 16'd2); nr = 2; end
      4'd4, 4'd5: begin
        q = {b1, b0};
        t = 16'(q + {8'h00, (m == 4'd4) ? xv : yv});
        e = t; c = (t[15:8] != q[15:8]); pn = 16'(p + 16'd2); nr = 2;
      end
      4'd6: begin
        q = {b1, b0};
        e = {mem_byte(16'(q + 16'd1)), mem_byte(q)};
        pn = 16'(p + 16'd2); nr = 4;
      end
      4'd7: begin
        z = 8'(b0 + xv); zn = 8'(z + 8'd1);
        e = {mem_byte({8'h00, zn}), mem_byte({8'h00, z})}; nr = 3;
      end
      4'd8: begin
        zn = 8'(b0 + 8'd1);
        q = {mem_byte({8'h00, zn}), mem_byte({8'h00, b0})};
        t = 16'(q + {8'h00, yv});
        e = t; c = (t[15:8] != q[15:8]); nr = 3;
      end
      4'd9: e = 16'(p + 16'd1 + {{8{b0[7]}}, b0});
      default: ;
    endcase
  endtask

  function automatic string tag_of(input logic [3:0] m);
    case (m)
      4'd3, 4'd4, 4'd5: return "R4";
      4'd6: return "R7";
      4'd7: return "R5";
      4'd8: return "R6";
      4'd9: return "R8";
      default: return "R3";
    endcase
  endfunction

  // wait for done (called on a negedge right after start was dropped)
  task automatic wait_check(input logic [3:0] m, input logic [15:0] p,
                            input logic [7:0] xv, input logic [7:0] yv,
                            input bit poke);
    logic [15:0] e, pn; logic c; int nr; int reads = 0; int n = 0;
    expect_of(m, p, xv, yv, e, c, pn, nr);
    while (!done && n < 20) begin
      if (rd_en) reads++;
      if (poke && n == 0) begin
        start = 1'b1; mode = 4'(m + 4'd3); pc_in = ~p; x_in = ~xv; y_in = ~yv;
      end
      if (poke && n == 1) start = 1'b0;
      @(negedge clk);
      n++;
    end
    chk("R10 done seen", {31'd0, done}, 32'd1);
    chk(tag_of(m), {16'd0, ea}, {16'd0, e});
    chk("R4/R6 page_cross", {31'd0, page_cross}, {31'd0, c});
    chk("R2 pc_next", {16'd0, pc_next}, {16'd0, pn});
    chk("R10 read count", reads, nr);
    if (poke) chk("R11 busy start ignored", {16'd0, ea}, {16'd0, e});
  endtask

  task automatic launch(input logic [3:0] m, input logic [15:0] p,
                        input logic [7:0] xv, input logic [7:0] yv);
    mode = m; pc_in = p; x_in = xv; y_in = yv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 busy after start", {31'd0, busy}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL R10 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 page_cross", {31'd0, page_cross}, 32'd0);
    chk("R1 rd_en", {31'd0, rd_en}, 32'd0);
    chk("R1 ea", {16'd0, ea}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // sweep every code, including undefined ones (R3)
    for (int m = 0; m < 12; m++) begin
      for (int k = 0; k < 40; k++) begin
        logic [15:0] p; logic [7:0] xv, yv;
        p  = {8'(k * 29 + m), (k % 3 == 0) ? 8'hFF : 8'(k * 53)};
        xv = (k == 1) ? 8'hFF : 8'(k * 41);
        yv = (k == 2) ? 8'hFF : 8'(k * 67 + 128);
        launch(4'(m), p, xv, yv);
        wait_check(4'(m), p, xv, yv, (k % 7 == 3));
        @(negedge clk);
      end
    end

    // R9: chain a new start onto a crossing result
    begin
      logic [15:0] p; logic [15:0] e, pn; logic c; int nr;
      p = 16'h12F0;
      while (mem_byte(p) == 8'h00) p = 16'(p + 16'd1);
      launch(4'd4, p, 8'hFF, 8'h00);
      wait_check(4'd4, p, 8'hFF, 8'h00, 1'b0);
      chk("R9 crossing set", {31'd0, page_cross}, 32'd1);
      expect_of(4'd0, 16'h0345, 8'h00, 8'h00, e, c, pn, nr);
      launch(4'd0, 16'h0345, 8'h00, 8'h00);
      chk("R9 cleared on start", {31'd0, page_cross}, 32'd0);
      chk("R10 done single pulse", {31'd0, done}, 32'd0);
      wait_check(4'd0, 16'h0345, 8'h00, 8'h00, 1'b0);
      repeat (3) @(negedge clk);
      chk("R9 ea held", {16'd0, ea}, {16'd0, e});
      chk("R10 done low when idle", {31'd0, done}, 32'd0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule